// File: doc/BRIEF.md
# Programmable Morse Element Clock

This block generates the element-rate timing pulse that an iambic-style keyer uses to time its dots, dashes and gaps. Its speed is chosen with a 5-bit select that reads directly in words per minute. The period follows the standard-word rule: a reference word plus its trailing gap spans 50 elements, so one element lasts 1.2 seconds divided by the speed. Because the period is taken from a table that is computed when the design is built for a given system clock, each whole-WPM setting always gives the same period and can be chosen again exactly.

The clock runs only while the element request input is held high, which happens while a paddle or key is closed. The first period starts on the first edge at which the request is seen, so the first tick comes one full element later. Releasing the request clears the divider at once. A running count of elapsed elements lets the sequencer that follows measure dots (one element), dashes (three elements), and the one-, three- and seven-element gaps.

Top module: `morse_elem_clk`

## Requirements
- R1: For a legal select w (10 to 26), the element period is T = floor(CLK_HZ*6/(5*w)) clock cycles. When the request is first sampled high at an edge counted as edge 1, tick is high after edge T, edge 2T, and so on. No tick occurs after any other edge.
- R2: Tick is high for exactly one clock cycle per element.
- R3: A select value below 10 acts as 10, and a value above 26 acts as 26.
- R4: While the request is low, tick stays low and the divider is held cleared. If the request is released on the edge that would have ended an element, no tick is produced. A new request always starts a full period T.
- R5: The element count clears on the first edge of a new request, rises by one on every tick, keeps its value after the request is released, and wraps modulo 2^CNT_W.
- R6: The period in use is reloaded only while the request is idle and on the edge that ends an element. A select change made during an element takes effect for the following element. A change that is present on the boundary edge itself applies to the very next element.
- R7: While reset is high, and just after reset, tick is 0 and the element count is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Element request; high while a key or paddle is closed |
| wpm_sel | input | 5 | Speed select in WPM; legal values are 10 to 26, others are clamped |
| tick | output | 1 | One-cycle pulse at the end of each element |
| elem_count | output | CNT_W | Number of elements elapsed in the current or most recent request |

## Verification
Two events can land on the same clock edge: the edge that ends an element, and either a change of the speed select or the release of the request. The bench changes the select half a cycle before a boundary edge, and checks that the very next element already uses the new period. It also changes the select half a cycle after a boundary, and checks that the current element keeps the old period. Finally, it drops the request just before a boundary edge, and checks that no tick appears and that the element count does not advance.

// File: rtl/morse_clk_pkg.sv
package morse_clk_pkg;

    localparam int WPM_MIN   = 10;
    localparam int WPM_MAX   = 26;
    localparam int WPM_STEPS = WPM_MAX - WPM_MIN + 1;

    typedef logic [4:0] wpm_sel_t;
    typedef logic [4:0] speed_idx_t;

    // Element length in clock cycles: 1.2 s / wpm == 6 / (5 * wpm) s
    function automatic longint elem_cycles(longint clk_hz, int wpm);
        return (clk_hz * 64'd6) / (64'd5 * longint'(wpm));
    endfunction

    // Width that holds the slowest (longest) element period
    function automatic int period_width(longint clk_hz);
        return $clog2(elem_cycles(clk_hz, WPM_MIN) + 1);
    endfunction

endpackage

// File: rtl/speed_clamp.sv
module speed_clamp
    import morse_clk_pkg::*;
(
    input  wpm_sel_t   raw_sel,
    output speed_idx_t idx
);

    always_comb begin
        if (raw_sel < 5'(WPM_MIN))
            idx = '0;
        else if (raw_sel > 5'(WPM_MAX))
            idx = 5'(WPM_STEPS - 1);
        else
            idx = raw_sel - 5'(WPM_MIN);
    end

endmodule

// File: rtl/period_lut.sv
module period_lut
    import morse_clk_pkg::*;
#(
    parameter longint CLK_HZ = 50_000_000,
    parameter int     PER_W  = 23
) (
    input  speed_idx_t       idx,
    output logic [PER_W-1:0] period
);

    logic [PER_W-1:0] tbl [WPM_STEPS];

    for (genvar g = 0; g < WPM_STEPS; g++) begin : g_entry
        assign tbl[g] = PER_W'(elem_cycles(CLK_HZ, WPM_MIN + g));
    end

    assign period = (idx < 5'(WPM_STEPS)) ? tbl[idx] : tbl[WPM_STEPS-1];

    // R3: the clamp stage must never hand an out-of-table index here
    always_comb begin
        a_idx_legal_r3: assert (idx < 5'(WPM_STEPS));
    end

endmodule

// File: rtl/elem_divider.sv
module elem_divider #(
    parameter int PER_W = 23,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req,
    input  logic [PER_W-1:0] period_next,
    output logic             tick_o,
    output logic [CNT_W-1:0] elem_o
);

    logic [PER_W-1:0] cnt_q;
    logic [PER_W-1:0] term_q;
    logic             req_q;
    logic             tick_q;
    logic [CNT_W-1:0] elem_q;

    logic [PER_W-1:0] cnt_base;
    logic [CNT_W-1:0] elem_base;
    logic             at_end;

    // A fresh request behaves as if the divider and count were zero
    assign cnt_base  = req_q ? cnt_q  : '0;
    assign elem_base = req_q ? elem_q : '0;
    assign at_end    = (cnt_base == term_q - 1'b1);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            term_q <= period_next;
            req_q  <= 1'b0;
            tick_q <= 1'b0;
            elem_q <= '0;
        end else begin
            req_q <= req;
            if (!req) begin
                cnt_q  <= '0;
                tick_q <= 1'b0;
                term_q <= period_next;
            end else if (at_end) begin
                cnt_q  <= '0;
                tick_q <= 1'b1;
                elem_q <= elem_base + 1'b1;
                term_q <= period_next;
            end else begin
                cnt_q  <= cnt_base + 1'b1;
                tick_q <= 1'b0;
                elem_q <= elem_base;
            end
        end
    end

    assign tick_o = tick_q;
    assign elem_o = elem_q;

    p_tick_needs_req_r4: assert property (@(posedge clk) disable iff (rst)
        tick_q |-> req_q);

    p_idle_clear_r4: assert property (@(posedge clk) disable iff (rst)
        !req_q |-> (cnt_q == '0));

    p_tick_pulse_r2: assert property (@(posedge clk) disable iff (rst)
        tick_q |=> !tick_q);

    p_cnt_bound_r1: assert property (@(posedge clk) disable iff (rst)
        cnt_q < term_q);

    p_term_boundary_r6: assert property (@(posedge clk) disable iff (rst)
        !$stable(term_q) |-> (tick_q || !req_q));

    p_elem_step_r5: assert property (@(posedge clk) disable iff (rst)
        (tick_q && $past(req_q)) |-> (elem_q == CNT_W'($past(elem_q) + 1'b1)));

endmodule

// File: rtl/morse_elem_clk.sv
module morse_elem_clk
    import morse_clk_pkg::*;
#(
    parameter longint CLK_HZ = 50_000_000,
    parameter int     CNT_W  = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req,
    input  logic [4:0]       wpm_sel,
    output logic             tick,
    output logic [CNT_W-1:0] elem_count
);

    localparam int PER_W = period_width(CLK_HZ);

    speed_idx_t       idx;
    logic [PER_W-1:0] period;

    speed_clamp u_clamp (
        .raw_sel (wpm_sel),
        .idx     (idx)
    );

    period_lut #(
        .CLK_HZ (CLK_HZ),
        .PER_W  (PER_W)
    ) u_lut (
        .idx    (idx),
        .period (period)
    );

    elem_divider #(
        .PER_W (PER_W),
        .CNT_W (CNT_W)
    ) u_div (
        .clk         (clk),
        .rst         (rst),
        .req         (req),
        .period_next (period),
        .tick_o      (tick),
        .elem_o      (elem_count)
    );

endmodule

// File: tb/morse_elem_clk_tb.sv
`timescale 1ns/1ps
module morse_elem_clk_tb;

    localparam longint HZ = 2000;
    localparam int     CW = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req = 1'b0;
    logic [4:0]    wpm_sel = 5'd10;
    logic          tick;
    logic [CW-1:0] elem_count;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    morse_elem_clk #(.CLK_HZ(HZ), .CNT_W(CW)) u_dut (
        .clk        (clk),
        .rst        (rst),
        .req        (req),
        .wpm_sel    (wpm_sel),
        .tick       (tick),
        .elem_count (elem_count)
    );

    always #2.5 clk = ~clk;

    function automatic int exp_period(int sel);
        int w;
        w = (sel < 10) ? 10 : ((sel > 26) ? 26 : sel);
        return int'((HZ * 6) / (5 * w));
    endfunction

    task automatic check(bit ok, string req_tag, string what, int act, int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: %s actual=%0d expected=%0d", req_tag, what, act, exp);
        end
    endtask

    task automatic step(output logic t);
        @(posedge clk);
        @(negedge clk);
        t = tick;
    endtask

    task automatic steps(int n);
        logic t;
        for (int i = 0; i < n; i++) step(t);
    endtask

    task automatic edges_to_tick(output int n);
        logic t;
        n = 0;
        t = 1'b0;
        while (!t && n < 3000) begin
            step(t);
            n++;
        end
    endtask

    task automatic fresh_start(int sel);
        req = 1'b0;
        wpm_sel = 5'(sel);
        steps(2);
        req = 1'b1;
    endtask

    initial begin
        int n;
        logic t;
        @(negedge clk);
        steps(3);
        // R7: reset state
        check(tick == 1'b0, "R7", "tick in reset", int'(tick), 0);
        check(elem_count == '0, "R7", "count in reset", int'(elem_count), 0);
        rst = 1'b0;
        steps(1);
        check(tick == 1'b0 && elem_count == '0, "R7", "state after reset",
              int'(elem_count), 0);

        // R1 R2 R3: sweep every select code, two elements each
        for (int sel = 0; sel < 32; sel++) begin
            int per, bad, bad_edge;
            string tg;
            per = exp_period(sel);
            tg = (sel < 10 || sel > 26) ? "R3" : "R1";
            fresh_start(sel);
            bad = 0;
            bad_edge = -1;
            for (int e = 1; e <= 2 * per + 3; e++) begin
                step(t);
                // R2: only single-cycle pulses at multiples of the period
                if (t != ((e % per) == 0)) begin
                    bad++;
                    if (bad_edge < 0) bad_edge = e;
                end
            end
            check(bad == 0, tg, $sformatf("sel %0d first tick mismatch at edge", sel),
                  bad_edge, -1);
            check(elem_count == 4'd2, "R5", $sformatf("sel %0d count", sel),
                  int'(elem_count), 2);
            req = 1'b0;
            step(t);
            check(t == 1'b0 && elem_count == 4'd2, "R4",
                  $sformatf("sel %0d idle after release, count", sel), int'(elem_count), 2);
        end

        // R4 R5: restart yields a full period and a cleared count
        fresh_start(26);
        steps(100);
        check(elem_count == 4'd1, "R5", "count before release", int'(elem_count), 1);
        req = 1'b0;
        steps(3);
        check(elem_count == 4'd1, "R5", "count held while idle", int'(elem_count), 1);
        req = 1'b1;
        step(t);
        check(elem_count == '0, "R5", "count cleared on new request", int'(elem_count), 0);
        edges_to_tick(n);
        check(n + 1 == 92, "R4", "edges to first tick after restart", n + 1, 92);

        // R4: release lands on the boundary edge
        fresh_start(10);
        steps(239);
        req = 1'b0;
        step(t);
        check(t == 1'b0, "R4", "tick on boundary with request low", int'(t), 0);
        check(elem_count == '0, "R4", "count on boundary with request low",
              int'(elem_count), 0);

        // R6: change during an element applies at the next boundary
        fresh_start(10);
        steps(100);
        wpm_sel = 5'd20;
        edges_to_tick(n);
        check(n == 140, "R6", "old period kept after mid-element change", n, 140);
        edges_to_tick(n);
        check(n == 120, "R6", "new period after boundary", n, 120);

        // R6: change present on the boundary edge itself
        fresh_start(10);
        steps(239);
        wpm_sel = 5'd24;
        edges_to_tick(n);
        check(n == 1, "R6", "boundary edge still ends old element", n, 1);
        wpm_sel = 5'd10;
        edges_to_tick(n);
        check(n == 100, "R6", "change on boundary used for next element", n, 100);
        edges_to_tick(n);
        check(n == 240, "R6", "change just after boundary deferred one element", n, 240);

        // R5: count wraps modulo 2^CW
        fresh_start(26);
        for (int k = 0; k < 17; k++) edges_to_tick(n);
        check(elem_count == 4'd1, "R5", "count wraps after 17 elements", int'(elem_count), 1);

        req = 1'b0;
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: run hung actual=%0d expected=%0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule